// File: doc/BRIEF.md
# Timeslot to Channel Mapper

The mapper routes serial bits from many independent line-side links onto a shared pool of logical HDLC channels. Each clock, any link may present one bit with a strobe and a frame-start marker. The block looks up the owning channel in a programmable table indexed by link and timeslot, and emits the bit with its channel number. It emits at most one bit per cycle. When several links hold bits at the same time, they are served in rotating order.

A link runs in one of two modes, and both modes can be active on different links at once. A channelized link is cut into 8-bit timeslots counted from its last frame start. Each timeslot has its own table entry, and any set of timeslots, adjacent or not, may point at the same channel. An unchannelized link sends every bit to the channel held in its slot-0 entry. Software writes a staging copy of the table and of the per-link mode. A link picks up those changes only at its next frame start, so a frame never mixes two mappings.

Top module: `slot_chan_mapper`

## Requirements
- R1: After reset, `outValid` is low, every table entry is invalid, and every link is channelized. A link has no known frame position until its first frame start, so bits on a channelized link before that point are dropped.
- R2: A bit presented with `linkFrameStart` high is bit offset 0 of a new frame. The timeslot of a bit is its offset since the last frame start divided by 8. The bit is emitted on `outBit` with `outChan` equal to the channel of the entry for its link and timeslot.
- R3: A bit whose entry has the valid flag clear is dropped. No `outValid` strobe is produced for it.
- R4: Several noncontiguous timeslots of one link may carry the same channel number, and all of their bits are emitted on that channel.
- R5: On an unchannelized link, every bit uses the slot-0 entry of that link, whatever its offset in the frame, including offsets beyond the channelized frame length.
- R6: On a channelized link, a bit whose offset since the last frame start is `MAX_SLOTS*8` or more is dropped.
- R7: Entry writes (`cfgEntryWe`) and mode writes (`cfgModeWe`, 1 = unchannelized) change only a staging copy. The staging copy of a link becomes active with the frame-start bit of that link's next frame, and that bit already uses it. A write in the same cycle as a frame start applies from the following frame.
- R8: With no contention, a bit accepted at clock edge k appears on the outputs after edge k+1 as a one-cycle `outValid` pulse.
- R9: Each cycle in which any accepted bit is waiting, exactly one bit is emitted. The link chosen is the first waiting link found by stepping upward, wrapping at the last link, starting from the link after the one served last (link 0 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| linkValid | input | NUM_LINKS | Per-link strobe: a bit is presented this cycle |
| linkFrameStart | input | NUM_LINKS | Per-link marker: the presented bit starts a frame |
| linkBit | input | NUM_LINKS | Per-link serial data bit |
| cfgEntryWe | input | 1 | Write one staging table entry |
| cfgLink | input | $clog2(NUM_LINKS) | Link addressed by an entry or mode write |
| cfgSlot | input | $clog2(MAX_SLOTS) | Timeslot addressed by an entry write |
| cfgEntryValid | input | 1 | Valid flag written into the entry |
| cfgChan | input | $clog2(NUM_CHANS) | Channel number written into the entry |
| cfgModeWe | input | 1 | Write the staging mode of `cfgLink` |
| cfgUnchan | input | 1 | Mode value: 1 unchannelized, 0 channelized |
| outValid | output | 1 | A mapped bit is on the outputs |
| outChan | output | $clog2(NUM_CHANS) | Channel owning the emitted bit |
| outBit | output | 1 | Emitted data bit |

## Verification
The bench builds the mapper with 4 links, 16 channels and 4 timeslots per frame. A whole channelized frame is then 32 bits, so the vector table can play several complete frames per link and step past the frame length to reach the drop-after-frame corner. Four links are enough for every link to hold a waiting bit at once, so rotating service can be checked both in plain ascending order and after the pointer has moved past lower-numbered links. The small table also leaves room to check mid-frame writes, writes in the same cycle as a frame start, and bits that arrive before the first frame start.

// File: rtl/scm_pkg.sv
package scm_pkg;

  // Widest link index the strobe bundle can carry (up to 32 links).
  localparam int LINK_IDX_W = 5;

  // Control-to-datapath strobes: which waiting link is emitted this cycle.
  typedef struct packed {
    logic                  serve;
    logic [LINK_IDX_W-1:0] link;
  } arbStrobe_t;

endpackage

// File: rtl/scm_arbiter.sv
module scm_arbiter
  import scm_pkg::*;
#(
  parameter int NUM_LINKS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINKS-1:0] pendValid,
  output arbStrobe_t           strb
);

  logic [LINK_IDX_W-1:0] rrPtr;
  logic [NUM_LINKS-1:0]  shifted;
  int                    idx;

  // Search starts at rrPtr and wraps; first waiting link wins.
  always_comb begin
    strb    = '0;
    shifted = '0;
    idx     = 0;
    for (int off = 0; off < NUM_LINKS; off++) begin
      idx = int'(rrPtr) + off;
      if (idx >= NUM_LINKS) idx = idx - NUM_LINKS;
      shifted = pendValid >> idx;
      if (!strb.serve && shifted[0]) begin
        strb.serve = 1'b1;
        strb.link  = LINK_IDX_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrPtr <= '0;
    end else if (strb.serve) begin
      if (int'(strb.link) == NUM_LINKS - 1) rrPtr <= '0;
      else                                  rrPtr <= strb.link + 1'b1;
    end
  end

endmodule

// File: rtl/scm_datapath.sv
module scm_datapath
  import scm_pkg::*;
#(
  parameter int NUM_LINKS = 32,
  parameter int NUM_CHANS = 128,
  parameter int MAX_SLOTS = 32,
  localparam int LINK_W   = $clog2(NUM_LINKS),
  localparam int CHAN_W   = $clog2(NUM_CHANS),
  localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINKS-1:0] linkValid,
  input  logic [NUM_LINKS-1:0] linkFrameStart,
  input  logic [NUM_LINKS-1:0] linkBit,
  input  logic                 cfgEntryWe,
  input  logic [LINK_W-1:0]    cfgLink,
  input  logic [SLOT_W-1:0]    cfgSlot,
  input  logic                 cfgEntryValid,
  input  logic [CHAN_W-1:0]    cfgChan,
  input  logic                 cfgModeWe,
  input  logic                 cfgUnchan,
  input  arbStrobe_t           strb,
  output logic [NUM_LINKS-1:0] pendValid,
  output logic                 outValid,
  output logic [CHAN_W-1:0]    outChan,
  output logic                 outBit
);

  // Offset counter: SLOT_W+3 bits of offset plus one "past the frame" bit.
  localparam int CNT_W = SLOT_W + 4;
  localparam logic [CNT_W-1:0] CNT_LOST = {1'b1, {(CNT_W-1){1'b0}}};

  // Staging and active copies of the mapping table and link modes.
  logic              stgVld  [NUM_LINKS][MAX_SLOTS];
  logic [CHAN_W-1:0] stgChan [NUM_LINKS][MAX_SLOTS];
  logic              actVld  [NUM_LINKS][MAX_SLOTS];
  logic [CHAN_W-1:0] actChan [NUM_LINKS][MAX_SLOTS];
  logic [NUM_LINKS-1:0] stgUnch;
  logic [NUM_LINKS-1:0] actUnch;

  logic [CNT_W-1:0]  posCnt  [NUM_LINKS];
  logic [NUM_LINKS-1:0] commit;
  logic [NUM_LINKS-1:0] hit;
  logic [CHAN_W-1:0] hitChan [NUM_LINKS];
  logic [NUM_LINKS-1:0] grant;
  logic [NUM_LINKS-1:0] pendBit;
  logic [CHAN_W-1:0] pendChan [NUM_LINKS];
  logic              selBit;
  logic [CHAN_W-1:0] selChan;

  assign commit = linkValid & linkFrameStart;

  // ---------------- staging writes ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stgUnch <= '0;
      for (int l = 0; l < NUM_LINKS; l++)
        for (int s = 0; s < MAX_SLOTS; s++)
          stgVld[l][s] <= 1'b0;
    end else begin
      if (cfgEntryWe) stgVld[cfgLink][cfgSlot] <= cfgEntryValid;
      if (cfgModeWe)  stgUnch[cfgLink]         <= cfgUnchan;
    end
  end

  always_ff @(posedge clk) begin
    if (cfgEntryWe) stgChan[cfgLink][cfgSlot] <= cfgChan;
  end

  // ---------------- commit at frame start ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      actUnch <= '0;
      for (int l = 0; l < NUM_LINKS; l++)
        for (int s = 0; s < MAX_SLOTS; s++)
          actVld[l][s] <= 1'b0;
    end else begin
      for (int l = 0; l < NUM_LINKS; l++) begin
        if (commit[l]) begin
          actUnch[l] <= stgUnch[l];
          for (int s = 0; s < MAX_SLOTS; s++)
            actVld[l][s] <= stgVld[l][s];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < NUM_LINKS; l++)
      if (commit[l])
        for (int s = 0; s < MAX_SLOTS; s++)
          actChan[l][s] <= stgChan[l][s];
  end

  // ---------------- frame position per link ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < NUM_LINKS; l++) posCnt[l] <= CNT_LOST;
    end else begin
      for (int l = 0; l < NUM_LINKS; l++) begin
        if (linkValid[l]) begin
          if (linkFrameStart[l])          posCnt[l] <= CNT_W'(1);
          else if (!posCnt[l][CNT_W-1])   posCnt[l] <= posCnt[l] + 1'b1;
        end
      end
    end
  end

  // ---------------- per-link lookup ----------------
  for (genvar g = 0; g < NUM_LINKS; g++) begin : gLookup
    logic              unchNow;
    logic              beyond;
    logic [SLOT_W-1:0] slotIdx;
    logic              entVld;

    always_comb begin
      // The frame-start bit reads the staging copy it is about to commit.
      unchNow = linkFrameStart[g] ? stgUnch[g] : actUnch[g];
      if (unchNow || linkFrameStart[g]) slotIdx = '0;
      else                              slotIdx = posCnt[g][CNT_W-2:3];
      beyond  = !unchNow && !linkFrameStart[g] && posCnt[g][CNT_W-1];
      if (linkFrameStart[g]) begin
        entVld     = stgVld[g][slotIdx];
        hitChan[g] = stgChan[g][slotIdx];
      end else begin
        entVld     = actVld[g][slotIdx];
        hitChan[g] = actChan[g][slotIdx];
      end
      hit[g] = linkValid[g] && entVld && !beyond;
    end

    assign grant[g] = strb.serve && (strb.link == LINK_IDX_W'(g));
  end

  // ---------------- one-bit holding stage per link ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendValid <= '0;
      pendBit   <= '0;
      for (int l = 0; l < NUM_LINKS; l++) pendChan[l] <= '0;
    end else begin
      for (int l = 0; l < NUM_LINKS; l++) begin
        if (hit[l]) begin
          pendValid[l] <= 1'b1;
          pendBit[l]   <= linkBit[l];
          pendChan[l]  <= hitChan[l];
        end else if (grant[l]) begin
          pendValid[l] <= 1'b0;
        end
      end
    end
  end

  // ---------------- output selection ----------------
  always_comb begin
    selBit  = 1'b0;
    selChan = '0;
    for (int l = 0; l < NUM_LINKS; l++) begin
      if (grant[l]) begin
        selBit  = pendBit[l];
        selChan = pendChan[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outChan  <= '0;
      outBit   <= 1'b0;
    end else begin
      outValid <= strb.serve;
      outChan  <= selChan;
      outBit   <= selBit;
    end
  end

endmodule

// File: rtl/slot_chan_mapper.sv
module slot_chan_mapper
  import scm_pkg::*;
#(
  parameter int NUM_LINKS = 32,
  parameter int NUM_CHANS = 128,
  parameter int MAX_SLOTS = 32,
  localparam int LINK_W   = $clog2(NUM_LINKS),
  localparam int CHAN_W   = $clog2(NUM_CHANS),
  localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINKS-1:0] linkValid,
  input  logic [NUM_LINKS-1:0] linkFrameStart,
  input  logic [NUM_LINKS-1:0] linkBit,
  input  logic                 cfgEntryWe,
  input  logic [LINK_W-1:0]    cfgLink,
  input  logic [SLOT_W-1:0]    cfgSlot,
  input  logic                 cfgEntryValid,
  input  logic [CHAN_W-1:0]    cfgChan,
  input  logic                 cfgModeWe,
  input  logic                 cfgUnchan,
  output logic                 outValid,
  output logic [CHAN_W-1:0]    outChan,
  output logic                 outBit
);

  arbStrobe_t           arbS;
  logic [NUM_LINKS-1:0] pendValid;

  scm_arbiter #(
    .NUM_LINKS(NUM_LINKS)
  ) arb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pendValid (pendValid),
    .strb      (arbS)
  );

  scm_datapath #(
    .NUM_LINKS(NUM_LINKS),
    .NUM_CHANS(NUM_CHANS),
    .MAX_SLOTS(MAX_SLOTS)
  ) dp_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .linkValid      (linkValid),
    .linkFrameStart (linkFrameStart),
    .linkBit        (linkBit),
    .cfgEntryWe     (cfgEntryWe),
    .cfgLink        (cfgLink),
    .cfgSlot        (cfgSlot),
    .cfgEntryValid  (cfgEntryValid),
    .cfgChan        (cfgChan),
    .cfgModeWe      (cfgModeWe),
    .cfgUnchan      (cfgUnchan),
    .strb           (arbS),
    .pendValid      (pendValid),
    .outValid       (outValid),
    .outChan        (outChan),
    .outBit         (outBit)
  );

endmodule

// File: rtl/slot_chan_mapper_chk.sv
module slot_chan_mapper_chk
  import scm_pkg::*;
#(
  parameter int NUM_LINKS = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINKS-1:0] pendValid,
  input arbStrobe_t           arbS,
  input logic                 outValid
);

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !outValid);                                          // R1

  AST_SERVE_HAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    arbS.serve |-> (|(pendValid & (NUM_LINKS'(1) << arbS.link))));         // R9

  AST_SERVE_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    arbS.serve |=> outValid);                                             // R8

  AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !arbS.serve |=> !outValid);                                           // R8

  AST_OUT_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(|pendValid));                                      // R9

endmodule

bind slot_chan_mapper slot_chan_mapper_chk #(.NUM_LINKS(NUM_LINKS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .pendValid (pendValid),
  .arbS      (arbS),
  .outValid  (outValid)
);

// File: tb/slot_chan_mapper_tb.sv
module slot_chan_mapper_tb_top;

  localparam int NL = 4;
  localparam int NC = 16;
  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] linkValid = '0;
  logic [NL-1:0] linkFrameStart = '0;
  logic [NL-1:0] linkBit = '0;
  logic          cfgEntryWe = 1'b0;
  logic [1:0]    cfgLink = '0;
  logic [1:0]    cfgSlot = '0;
  logic          cfgEntryValid = 1'b0;
  logic [3:0]    cfgChan = '0;
  logic          cfgModeWe = 1'b0;
  logic          cfgUnchan = 1'b0;
  logic          outValid;
  logic [3:0]    outChan;
  logic          outBit;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  slot_chan_mapper #(.NUM_LINKS(NL), .NUM_CHANS(NC), .MAX_SLOTS(NS)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .linkValid(linkValid), .linkFrameStart(linkFrameStart), .linkBit(linkBit),
    .cfgEntryWe(cfgEntryWe), .cfgLink(cfgLink), .cfgSlot(cfgSlot),
    .cfgEntryValid(cfgEntryValid), .cfgChan(cfgChan),
    .cfgModeWe(cfgModeWe), .cfgUnchan(cfgUnchan),
    .outValid(outValid), .outChan(outChan), .outBit(outBit)
  );

  // {link[1:0], frame data (bit b sent b-th), slot emit mask, chan per slot {s3,s2,s1,s0}}
  localparam logic [53:0] VEC [4] = '{
    {2'd0, 32'hA5C3_0F96, 4'b1101, 16'h9303},
    {2'd1, 32'h1234_5678, 4'b1111, 16'h5555},
    {2'd0, 32'h0000_FFFF, 4'b1101, 16'h9303},
    {2'd1, 32'hF0F0_0FF0, 4'b1111, 16'h5555}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkOut(input logic expV, input logic [3:0] expC, input logic expB,
                          input string req);
    check(outValid === expV, {req, " valid"}, int'(outValid), int'(expV));
    if (expV) begin
      check(outChan === expC, {req, " chan"}, int'(outChan), int'(expC));
      check(outBit === expB, {req, " bit"}, int'(outBit), int'(expB));
    end
  endtask

  task automatic writeEntry(input logic [1:0] l, input logic [1:0] s, input logic v,
                            input logic [3:0] c);
    @(negedge clk);
    cfgEntryWe = 1'b1; cfgLink = l; cfgSlot = s; cfgEntryValid = v; cfgChan = c;
    @(negedge clk);
    cfgEntryWe = 1'b0;
  endtask

  task automatic writeMode(input logic [1:0] l, input logic u);
    @(negedge clk);
    cfgModeWe = 1'b1; cfgLink = l; cfgUnchan = u;
    @(negedge clk);
    cfgModeWe = 1'b0;
  endtask

  // Present one bit, then sample after the second rising edge (R8 latency).
  task automatic doBit(input logic [1:0] l, input logic fs, input logic b,
                       input logic expV, input logic [3:0] expC, input string req);
    @(negedge clk);
    linkValid[l] = 1'b1; linkFrameStart[l] = fs; linkBit[l] = b;
    @(negedge clk);
    linkValid = '0; linkFrameStart = '0; linkBit = '0;
    @(negedge clk);
    checkOut(expV, expC, b, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOut(1'b0, 4'd0, 1'b0, "R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    checkOut(1'b0, 4'd0, 1'b0, "R1 after reset");

    // Link0 channelized: slot0->3, slot2->3 (noncontiguous), slot3->9, slot1 invalid.
    writeEntry(2'd0, 2'd0, 1'b1, 4'd3);
    writeEntry(2'd0, 2'd2, 1'b1, 4'd3);
    writeEntry(2'd0, 2'd3, 1'b1, 4'd9);
    writeMode(2'd1, 1'b1);
    writeEntry(2'd1, 2'd0, 1'b1, 4'd5);
    writeEntry(2'd2, 2'd0, 1'b1, 4'd10);
    writeMode(2'd3, 1'b1);
    writeEntry(2'd3, 2'd0, 1'b1, 4'd14);

    // R1/R7: no frame start yet, nothing committed, position unknown.
    doBit(2'd2, 1'b0, 1'b1, 1'b0, 4'd0, "R1 before first frame start");
    doBit(2'd3, 1'b0, 1'b1, 1'b0, 4'd0, "R7 mode not yet committed");

    // Vector walk: whole frames (R2 R3 R4 R5).
    for (int v = 0; v < 4; v++) begin
      logic [1:0]  vl;
      logic [31:0] vd;
      logic [3:0]  vm;
      logic [15:0] vc;
      {vl, vd, vm, vc} = VEC[v];
      for (int b = 0; b < 32; b++) begin
        int sl;
        sl = b / 8;
        doBit(vl, b == 0, 1'(vd >> b), 1'(vm >> sl), 4'(vc >> (sl * 4)),
              "R2 R3 R4 R5 frame vector");
      end
    end

    // R6: link0 is 32 bits past its frame start -> drop. R5: unchannelized keeps going.
    doBit(2'd0, 1'b0, 1'b1, 1'b0, 4'd0, "R6 past frame end");
    doBit(2'd1, 1'b0, 1'b1, 1'b1, 4'd5, "R5 unchannelized past frame end");

    // R7: mid-frame write waits for the next frame start.
    doBit(2'd0, 1'b1, 1'b1, 1'b1, 4'd3, "R7 frame A slot0");
    for (int b = 1; b < 8; b++) doBit(2'd0, 1'b0, 1'b0, 1'b1, 4'd3, "R7 frame A slot0");
    writeEntry(2'd0, 2'd1, 1'b1, 4'd12);
    doBit(2'd0, 1'b0, 1'b1, 1'b0, 4'd0, "R7 old mapping holds mid-frame");
    doBit(2'd0, 1'b1, 1'b1, 1'b1, 4'd3, "R7 frame B slot0");
    for (int b = 1; b < 8; b++) doBit(2'd0, 1'b0, 1'b1, 1'b1, 4'd3, "R7 frame B slot0");
    doBit(2'd0, 1'b0, 1'b0, 1'b1, 4'd12, "R7 new mapping at next frame");

    // R7: write in the same cycle as a frame start applies one frame later.
    @(negedge clk);
    cfgEntryWe = 1'b1; cfgLink = 2'd0; cfgSlot = 2'd0; cfgEntryValid = 1'b1; cfgChan = 4'd7;
    linkValid[0] = 1'b1; linkFrameStart[0] = 1'b1; linkBit[0] = 1'b1;
    @(negedge clk);
    cfgEntryWe = 1'b0; linkValid = '0; linkFrameStart = '0; linkBit = '0;
    @(negedge clk);
    checkOut(1'b1, 4'd3, 1'b1, "R7 same-cycle write not yet active");
    doBit(2'd0, 1'b1, 1'b0, 1'b1, 4'd7, "R7 same-cycle write active next frame");

    // R9: put the pointer at link 0 via a lone grant to link 3.
    doBit(2'd3, 1'b1, 1'b1, 1'b1, 4'd14, "R5 R9 link3 unchannelized");

    // R9/R8: all four links at once -> 0,1,2,3 on consecutive cycles.
    @(negedge clk);
    linkValid = 4'b1111; linkFrameStart = 4'b1111; linkBit = 4'b0101;
    @(negedge clk);
    linkValid = '0; linkFrameStart = '0; linkBit = '0;
    checkOut(1'b0, 4'd0, 1'b0, "R8 no output one edge after capture");
    @(negedge clk); checkOut(1'b1, 4'd7,  1'b1, "R9 rr first link0");
    @(negedge clk); checkOut(1'b1, 4'd5,  1'b0, "R9 rr second link1");
    @(negedge clk); checkOut(1'b1, 4'd10, 1'b1, "R9 rr third link2");
    @(negedge clk); checkOut(1'b1, 4'd14, 1'b0, "R9 rr fourth link3");
    @(negedge clk); checkOut(1'b0, 4'd0,  1'b0, "R9 rr drained");

    // R9: after serving link1 alone, link3 outranks link0.
    doBit(2'd1, 1'b1, 1'b1, 1'b1, 4'd5, "R9 lone link1");
    @(negedge clk);
    linkValid = 4'b1001; linkFrameStart = 4'b1001; linkBit = 4'b0001;
    @(negedge clk);
    linkValid = '0; linkFrameStart = '0; linkBit = '0;
    @(negedge clk); checkOut(1'b1, 4'd14, 1'b0, "R9 rotated first link3");
    @(negedge clk); checkOut(1'b1, 4'd7,  1'b1, "R9 rotated second link0");

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule